// File: doc/BRIEF.md
# Cross-Domain Register Access Bridge

This block lets a processor running on a fast bus clock read and write 32-bit registers that sit in a slow, always-on timekeeping domain. The processor sees a small memory-mapped window of four word registers. Software first loads a target address, an access-kind code and, for writes, a data word. It then sets bit 0 of the control register to launch the transfer.

The launch request crosses into the slow clock as a toggle through a two-flop synchronizer. The slow side performs exactly one access on its synchronous register port, marked by a strobe one slow cycle wide. For a read, it captures the returned word during that strobe cycle. It then sends an acknowledge toggle back through a second two-flop synchronizer. The control register reads one from the launch until the acknowledge has been absorbed, and zero afterwards. Software polls it for completion.

While a transfer is in flight, the processor-side address, code and data registers are frozen, so the slow side samples stable values. When a read completes, the captured word replaces the contents of the data register in the same cycle that the control register returns to zero.

Top module: `cdc_reg_bridge`

## Requirements
- R1: After both resets, the control, access-code, address and data registers all read 0 and the slow-side strobe is low.
- R2: The window decodes byte offsets 0x0 (control, bit 0 = busy), 0x4 (access code, 8 bits, upper 24 bits read 0), 0x8 (address) and 0xC (data). Offsets with bits [1:0] nonzero are ignored.
- R3: Writing 1 to bit 0 of control while idle launches one transfer. Control reads 1 from the next cycle until completion and then reads 0. Writing 0 to control launches nothing.
- R4: An access code of 0x00 is a read. The slow port shows `slv_wr` = 0 and the held address. After completion, the data register holds the word the port returned.
- R5: Any nonzero access code (software uses 0xF1) is a write. The slow port shows `slv_wr` = 1, the held address, the held data word and the code on `slv_code`.
- R6: While busy, writes to the access-code, address, data and control registers are ignored. The held values and the count of transfers are unchanged.
- R7: Each launch produces exactly one slow-side strobe, one slow cycle wide. The acknowledge is sent only after that strobe.
- R8: After a write transfer completes, the data register still holds the word that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor bus clock |
| cpu_rst_n | input | 1 | Active-low reset, processor domain |
| cpu_sel | input | 1 | Window access valid |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_ofs | input | 4 | Byte offset into the window |
| cpu_wdata | input | 32 | Write data from the processor |
| cpu_rdata | output | 32 | Read data for the addressed register (combinational) |
| slow_clk | input | 1 | Always-on slow clock |
| slow_rst_n | input | 1 | Active-low reset, slow domain |
| slv_stb | output | 1 | One-cycle access strobe to the slow registers |
| slv_wr | output | 1 | Access is a write |
| slv_code | output | 8 | Access code as loaded by software |
| slv_addr | output | 32 | Target register address |
| slv_wdata | output | 32 | Write data |
| slv_rdata | input | 32 | Read data, valid during the strobe cycle |

## Verification
A launch toggle that is lost or duplicated shows at the ports within a few slow cycles. Either control stays at 1 forever, or the peripheral sees a second strobe that the bench counts. A stale capture or a missed completion edge shows as a wrong data-register value on the first read after control drops to zero. A hold register that accepts a write while busy shows on an address or data readback taken during the transfer, and again as a wrong word written into the bench's peripheral model.

// File: rtl/cdc_brg_pkg.sv
package cdc_brg_pkg;

  localparam int unsigned DW = 32;
  localparam int unsigned AW = 32;
  localparam int unsigned CW = 8;

  typedef enum logic [1:0] {
    WIN_CTRL = 2'd0,
    WIN_CODE = 2'd1,
    WIN_ADDR = 2'd2,
    WIN_DATA = 2'd3
  } win_reg_e;

  function automatic win_reg_e win_decode(input logic [3:0] ofs);
    return win_reg_e'(ofs[3:2]);
  endfunction

  function automatic logic win_aligned(input logic [3:0] ofs);
    return ofs[1:0] == 2'b00;
  endfunction

  function automatic logic code_is_write(input logic [CW-1:0] code);
    return code != '0;
  endfunction

endpackage

// File: rtl/cdc_brg_sync.sv
module cdc_brg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cdc_brg_cpu_regs.sv
module cdc_brg_cpu_regs
  import cdc_brg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [3:0]    ofs,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          req_tgl,
  input  logic          ack_sync,
  input  logic [DW-1:0] rd_cap,
  output logic [CW-1:0] code_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  logic     ack_seen;
  logic     busy;
  logic     done;
  logic     hit;
  logic     start;
  win_reg_e which;

  assign which = win_decode(ofs);
  assign hit   = sel && wr && win_aligned(ofs);
  assign busy  = req_tgl ^ ack_seen;
  assign done  = ack_sync ^ ack_seen;
  assign start = hit && (which == WIN_CTRL) && wdata[0] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl  <= 1'b0;
      ack_seen <= 1'b0;
      code_q   <= '0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      ack_seen <= ack_sync;
      if (start) req_tgl <= ~req_tgl;
      if (done && !code_is_write(code_q)) data_q <= rd_cap;
      if (hit && !busy) begin
        unique case (which)
          WIN_CODE: code_q <= wdata[CW-1:0];
          WIN_ADDR: addr_q <= wdata;
          WIN_DATA: data_q <= wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (which)
      WIN_CTRL: rdata = {{(DW-1){1'b0}}, busy};
      WIN_CODE: rdata = {{(DW-CW){1'b0}}, code_q};
      WIN_ADDR: rdata = addr_q;
      default:  rdata = data_q;
    endcase
  end

  // R3: an accepted launch raises busy on the next cycle
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R3: completion is only seen for an outstanding transfer
  a_r3_done_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R6: held address and code stay put under writes while busy
  a_r6_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(addr_q));
  a_r6_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(code_q));
endmodule

// File: rtl/cdc_brg_slow_port.sv
module cdc_brg_slow_port
  import cdc_brg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_sync,
  input  logic [CW-1:0] code_h,
  input  logic [AW-1:0] addr_h,
  input  logic [DW-1:0] data_h,
  input  logic [DW-1:0] port_rdata,
  output logic          stb,
  output logic          is_wr,
  output logic [CW-1:0] code_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          ack_tgl,
  output logic [DW-1:0] rd_cap
);
  logic req_seen;
  logic new_req;

  assign new_req = req_sync ^ req_seen;
  assign is_wr   = code_is_write(code_h);
  assign code_o  = code_h;
  assign addr_o  = addr_h;
  assign wdata_o = data_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      stb      <= 1'b0;
      ack_tgl  <= 1'b0;
      rd_cap   <= '0;
    end else begin
      stb <= new_req;
      if (new_req) req_seen <= req_sync;
      if (stb) begin
        ack_tgl <= ~ack_tgl;
        if (!is_wr) rd_cap <= port_rdata;
      end
    end
  end

  // R7: the strobe is exactly one slow cycle wide
  a_r7_one_cycle_stb: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
  // R7: the acknowledge toggles only right after a strobe
  a_r7_ack_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_tgl != $past(ack_tgl)) |-> $past(stb));
endmodule

// File: rtl/cdc_reg_bridge.sv
module cdc_reg_bridge
  import cdc_brg_pkg::*;
(
  input  logic          cpu_clk,
  input  logic          cpu_rst_n,
  input  logic          cpu_sel,
  input  logic          cpu_wr,
  input  logic [3:0]    cpu_ofs,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          slow_clk,
  input  logic          slow_rst_n,
  output logic          slv_stb,
  output logic          slv_wr,
  output logic [CW-1:0] slv_code,
  output logic [AW-1:0] slv_addr,
  output logic [DW-1:0] slv_wdata,
  input  logic [DW-1:0] slv_rdata
);
  logic          req_tgl, req_sync;
  logic          ack_tgl, ack_sync;
  logic [DW-1:0] rd_cap;
  logic [CW-1:0] code_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  cdc_brg_cpu_regs u_cpu (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .sel(cpu_sel), .wr(cpu_wr),
    .ofs(cpu_ofs), .wdata(cpu_wdata), .rdata(cpu_rdata),
    .req_tgl(req_tgl), .ack_sync(ack_sync), .rd_cap(rd_cap),
    .code_q(code_q), .addr_q(addr_q), .data_q(data_q)
  );

  cdc_brg_sync #(.STAGES(2)) u_req_sync (
    .clk(slow_clk), .rst_n(slow_rst_n), .d(req_tgl), .q(req_sync)
  );

  cdc_brg_sync #(.STAGES(2)) u_ack_sync (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .d(ack_tgl), .q(ack_sync)
  );

  cdc_brg_slow_port u_slow (
    .clk(slow_clk), .rst_n(slow_rst_n), .req_sync(req_sync),
    .code_h(code_q), .addr_h(addr_q), .data_h(data_q),
    .port_rdata(slv_rdata), .stb(slv_stb), .is_wr(slv_wr),
    .code_o(slv_code), .addr_o(slv_addr), .wdata_o(slv_wdata),
    .ack_tgl(ack_tgl), .rd_cap(rd_cap)
  );
endmodule

// File: tb/cdc_reg_bridge_tb.sv
module cdc_reg_bridge_tb_top;
  logic        cpu_clk = 0, slow_clk = 0;
  logic        cpu_rst_n = 0, slow_rst_n = 0;
  logic        cpu_sel = 0, cpu_wr = 0;
  logic [3:0]  cpu_ofs = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata;
  logic        slv_stb, slv_wr;
  logic [7:0]  slv_code;
  logic [31:0] slv_addr, slv_wdata, slv_rdata;

  int errors = 0, checks = 0;
  int stb_count = 0;
  bit wide_stb = 0;
  bit finished = 0;
  logic        prev_stb = 0;
  logic [31:0] periph [16];
  logic [31:0] mirror [16];

  always #10 cpu_clk = ~cpu_clk;
  always #35 slow_clk = ~slow_clk;

  cdc_reg_bridge dut_i (
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_ofs(cpu_ofs), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .slow_clk(slow_clk), .slow_rst_n(slow_rst_n), .slv_stb(slv_stb), .slv_wr(slv_wr),
    .slv_code(slv_code), .slv_addr(slv_addr), .slv_wdata(slv_wdata), .slv_rdata(slv_rdata)
  );

  assign slv_rdata = periph[slv_addr[5:2]];

  always @(posedge slow_clk) begin
    if (slv_stb) begin
      stb_count <= stb_count + 1;
      if (slv_wr) periph[slv_addr[5:2]] <= slv_wdata;
    end
    if (slv_stb && prev_stb) wide_stb <= 1;
    prev_stb <= slv_stb;
  end

  // {code, address, data}
  localparam logic [71:0] VEC [8] = '{
    {8'hF1, 32'h0000_0004, 32'hDEAD_BEEF},
    {8'h00, 32'h0000_0004, 32'h0000_0000},
    {8'h00, 32'h0000_0010, 32'h0000_0000},
    {8'hF1, 32'h0000_003C, 32'h1234_5678},
    {8'h01, 32'h0000_0000, 32'hA5A5_0F0F},
    {8'h00, 32'h0000_003C, 32'h0000_0000},
    {8'h00, 32'h0000_0000, 32'h0000_0000},
    {8'h00, 32'h0000_0020, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] o, input logic [31:0] v);
    @(negedge cpu_clk);
    cpu_sel = 1; cpu_wr = 1; cpu_ofs = o; cpu_wdata = v;
    @(negedge cpu_clk);
    cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic bus_rd(input logic [3:0] o, output logic [31:0] v);
    @(negedge cpu_clk);
    cpu_ofs = o;
    #2 v = cpu_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] c;
    c = 1;
    for (int i = 0; i < 400 && c != 0; i++) bus_rd(4'h0, c);
    check(req, c, 32'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge cpu_clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    int n0;
    for (int i = 0; i < 16; i++) begin
      periph[i] = 32'h1111_0000 + i * 32'h0101;
      mirror[i] = periph[i];
    end
    repeat (4) @(posedge cpu_clk);
    cpu_rst_n = 1; slow_rst_n = 1;
    repeat (2) @(posedge cpu_clk);

    // R1 reset state
    bus_rd(4'h0, v); check("R1 ctrl", v, 0);
    bus_rd(4'h4, v); check("R1 code", v, 0);
    bus_rd(4'h8, v); check("R1 addr", v, 0);
    bus_rd(4'hC, v); check("R1 data", v, 0);
    check("R1 strobe", {31'b0, slv_stb}, 0);

    // vector table: R4 reads, R5 writes, R8 data held after write
    for (int k = 0; k < 8; k++) begin
      logic [7:0]  code;
      logic [31:0] a, d;
      {code, a, d} = VEC[k];
      n0 = stb_count;
      bus_wr(4'h4, {24'b0, code});
      bus_wr(4'h8, a);
      bus_wr(4'hC, d);
      bus_wr(4'h0, 32'h1);
      bus_rd(4'h0, v); check("R3 busy after launch", v, 1);
      wait_idle("R3 completes");
      repeat (12) @(posedge cpu_clk);
      check("R7 one strobe", stb_count - n0, 1);
      if (code != 0) begin
        mirror[a[5:2]] = d;
        check("R5 periph written", periph[a[5:2]], d);
        check("R5 slv_code", {24'b0, slv_code}, {24'b0, code});
        bus_rd(4'hC, v); check("R8 data kept", v, d);
      end else begin
        bus_rd(4'hC, v); check("R4 read result", v, mirror[a[5:2]]);
        check("R4 slv_wr", {31'b0, slv_wr}, 0);
      end
    end

    // R3 writing 0 to control launches nothing
    n0 = stb_count;
    bus_wr(4'h0, 32'h0);
    repeat (40) @(posedge cpu_clk);
    check("R3 zero write no strobe", stb_count - n0, 0);
    bus_rd(4'h0, v); check("R3 ctrl stays 0", v, 0);

    // R2 code width, misaligned write ignored
    bus_wr(4'h4, 32'hFFFF_FFFF);
    bus_rd(4'h4, v); check("R2 code upper zero", v, 32'h0000_00FF);
    bus_wr(4'h9, 32'h5555_5555);
    bus_rd(4'h8, v); check("R2 misaligned ignored", v, 32'h0000_0020);

    // R6 writes while busy ignored
    bus_wr(4'h4, 32'hF1);
    bus_wr(4'h8, 32'h0000_0008);
    bus_wr(4'hC, 32'hCAFE_F00D);
    n0 = stb_count;
    bus_wr(4'h0, 32'h1);
    bus_wr(4'h8, 32'h0000_000C);
    bus_wr(4'hC, 32'h0BAD_0BAD);
    bus_wr(4'h4, 32'h00);
    bus_wr(4'h0, 32'h1);
    bus_rd(4'h8, v); check("R6 addr frozen", v, 32'h0000_0008);
    bus_rd(4'hC, v); check("R6 data frozen", v, 32'hCAFE_F00D);
    bus_rd(4'h4, v); check("R6 code frozen", v, 32'hF1);
    wait_idle("R6 completes");
    repeat (40) @(posedge cpu_clk);
    check("R6 single transfer", stb_count - n0, 1);
    check("R6 periph word", periph[2], 32'hCAFE_F00D);
    check("R6 other word untouched", periph[3], mirror[3]);
    check("R7 strobe width", {31'b0, wide_stb}, 0);

    summary();
  end
endmodule